// File: doc/BRIEF.md
# Compare and Decrement Arithmetic Unit

This block carries out one small group of 8-bit instructions that work on a register operand without an accumulator. The group is bitwise complement, compare, compare with carry, decimal adjust, byte decrement and 16-bit pair decrement. The sequencer presents one instruction per cycle. It drives the opcode byte and a marker that says whether an escape prefix came before it. It also drives the destination operand (a full 16-bit pair for the word decrement, otherwise the low byte), the source operand and the current flag register.

One clock edge later the unit returns four things: the value to write back, a write strobe, the whole updated flag register, and a valid pulse. Each instruction has its own flag rule. A flag is recomputed, kept, forced to zero, or (for decimal adjust) left to whatever the unit drives. The two compare forms only change flags and never ask for a write. Compare with carry chains its zero flag, so that a multi-byte compare works one byte at a time.

Top module: `cmpdec_alu`

## Requirements
- R1: Flags travel as a 6-bit vector with carry at bit 5, zero at bit 4, sign at bit 3, overflow at bit 2, decimal at bit 1 and half-carry at bit 0. Opcodes 0x60/0x61 select complement, 0x40/0x41 decimal adjust, 0x30/0x31 byte decrement, 0x80/0x81 word decrement and 0xA2 to 0xA9 compare, all with the prefix marker low. The marker high with 0xA2 to 0xA9 selects compare with carry. Any other combination writes nothing, returns result 0 and passes the flags through unchanged.
- R2: Complement returns the inverted low destination byte with write enabled. Zero and sign come from that byte, overflow becomes 0, and carry, decimal and half-carry are kept.
- R3: Compare forms destination minus source. Carry is the unsigned borrow, zero and sign come from the difference, and overflow is set when the operand signs differ and the difference's sign differs from the destination's. Decimal and half-carry are kept, write stays low and the result is 0.
- R4: Compare with carry also subtracts the incoming carry and uses the compare rules for carry, sign and overflow. Its zero flag is the incoming zero ANDed with a zero difference. Write stays low.
- R5: Byte decrement returns the low destination byte minus one with write enabled. Zero, sign and overflow come from the result (overflow only when 0x80 goes to 0x7F), and carry, decimal and half-carry are kept.
- R6: Word decrement returns the 16-bit destination minus one with write enabled. The R5 flag rule applies to the 16-bit result, with sign at bit 15 and overflow only when 0x8000 goes to 0x7FFF.
- R7: Decimal adjust with decimal flag 0 adds 0x06 when half-carry is set or the low nibble is above 9. It adds 0x60 and sets carry when carry is set or the byte is above 0x99, and otherwise clears carry.
- R8: Decimal adjust with decimal flag 1 subtracts 0x06 when half-carry is set and 0x60 when carry is set, and keeps carry. In both modes decimal adjust writes, takes zero and sign from the result, drives overflow to 0, and keeps decimal and half-carry.
- R9: Outputs are registered. A valid input at one rising edge yields out_valid and the outputs right after that edge. With in_valid low, out_valid and wr_en go low and result and flags_out hold.
- R10: A synchronous active-high reset clears out_valid, wr_en, result and all flags to 0, and it wins over a valid input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| pre_en | input | 1 | Escape prefix preceded the opcode |
| opcode | input | 8 | Instruction opcode byte |
| dst_in | input | 16 | Destination operand (pair for word decrement) |
| src_in | input | 8 | Source operand for compares |
| flags_in | input | 6 | Current flag register, layout per R1 |
| out_valid | output | 1 | Registered result valid |
| wr_en | output | 1 | Write the result back to the destination |
| result | output | 16 | Value to write back |
| flags_out | output | 6 | Updated flag register |

## Verification
Some rules are checked on every cycle at the ports. These are the one-cycle latency of the valid pulse, the missing write strobe on both compare forms, and the carry, decimal and half-carry bits kept by complement and byte decrement. Also checked every cycle are the zero flag that never rises across compare with carry, the flags holding while idle, and the reset state. The arithmetic itself needs the bench's vectors to show it. That covers the borrow and overflow of the subtractions, the 0x80 and 0x8000 decrement edges, both decimal-adjust correction paths, and the illegal opcodes at the edges of the compare range.

// File: rtl/cmpdec_pkg.sv
package cmpdec_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_COM  = 3'd1,
    OP_CP   = 3'd2,
    OP_CPC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_DECW = 3'd5,
    OP_DA   = 3'd6
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
    logic d;
    logic h;
  } flags_t;

  localparam int FLAG_W = 6;
endpackage

// File: rtl/cmpdec_decode.sv
module cmpdec_decode
  import cmpdec_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             pre_en,
  input  logic [OPC_W-1:0] opcode,
  output alu_op_e          op
);
  localparam logic [OPC_W-1:0] CMP_LO = OPC_W'(8'hA2);
  localparam logic [OPC_W-1:0] CMP_HI = OPC_W'(8'hA9);

  logic in_cmp_range;
  logic [OPC_W-2:0] pair;

  assign in_cmp_range = (opcode >= CMP_LO) && (opcode <= CMP_HI);
  assign pair = opcode[OPC_W-1:1];

  always_comb begin
    op = OP_NONE;
    if (pre_en) begin
      if (in_cmp_range) op = OP_CPC;
    end else if (in_cmp_range) begin
      op = OP_CP;
    end else begin
      case (pair)
        (OPC_W-1)'(8'h60 >> 1): op = OP_COM;
        (OPC_W-1)'(8'h40 >> 1): op = OP_DA;
        (OPC_W-1)'(8'h30 >> 1): op = OP_DEC;
        (OPC_W-1)'(8'h80 >> 1): op = OP_DECW;
        default:                op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmpdec_sub.sv
module cmpdec_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         borrow,
  output logic         ovf,
  output logic         zero
);
  logic [W:0] wide;

  assign wide   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
  assign diff   = wide[W-1:0];
  assign borrow = wide[W];
  assign ovf    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
  assign zero   = (diff == '0);
endmodule

// File: rtl/cmpdec_dadj.sv
module cmpdec_dadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         c_in,
  input  logic         h_in,
  input  logic         d_in,
  output logic [W-1:0] res,
  output logic         c_out
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
  localparam logic [W-1:0]   LO_FIX  = W'(6);
  localparam logic [W-1:0]   HI_FIX  = W'(6) << NIB;
  localparam logic [W-1:0]   BYTE_MAX = {DIG_MAX, DIG_MAX};

  logic fix_lo, fix_hi;
  logic [W-1:0] corr;

  always_comb begin
    if (!d_in) begin
      fix_lo = h_in || (a[NIB-1:0] > DIG_MAX);
      fix_hi = c_in || (a > BYTE_MAX);
    end else begin
      fix_lo = h_in;
      fix_hi = c_in;
    end
    corr  = (fix_lo ? LO_FIX : '0) | (fix_hi ? HI_FIX : '0);
    res   = d_in ? (a - corr) : (a + corr);
    c_out = d_in ? c_in : fix_hi;
  end
endmodule

// File: rtl/cmpdec_alu.sv
module cmpdec_alu
  import cmpdec_pkg::*;
#(
  parameter int W     = 8,
  parameter int OPC_W = 8,
  parameter int DW    = 2 * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              pre_en,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DW-1:0]     dst_in,
  input  logic [W-1:0]      src_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic              wr_en,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flags_out
);
  if (W != 8) begin : g_width_check
    $error("cmpdec_alu: decimal adjust needs an 8-bit data path");
  end

  alu_op_e op;
  flags_t  fin, fnx;
  logic [W-1:0]  d_lo, sub_b, sb_diff, da_res, com_res;
  logic          sub_bin, sb_borrow, sb_ovf, sb_zero, da_c;
  logic [DW-1:0] w_diff, res_nx;
  logic          w_borrow, w_ovf, w_zero, we_nx;

  assign fin  = flags_t'(flags_in);
  assign d_lo = dst_in[W-1:0];

  cmpdec_decode #(.OPC_W(OPC_W)) u_dec (
    .pre_en (pre_en),
    .opcode (opcode),
    .op     (op)
  );

  assign sub_b   = (op == OP_DEC) ? W'(1) : src_in;
  assign sub_bin = (op == OP_CPC) ? fin.c : 1'b0;

  cmpdec_sub #(.W(W)) u_sub_byte (
    .a      (d_lo),
    .b      (sub_b),
    .bin    (sub_bin),
    .diff   (sb_diff),
    .borrow (sb_borrow),
    .ovf    (sb_ovf),
    .zero   (sb_zero)
  );

  cmpdec_sub #(.W(DW)) u_sub_word (
    .a      (dst_in),
    .b      (DW'(1)),
    .bin    (1'b0),
    .diff   (w_diff),
    .borrow (w_borrow),
    .ovf    (w_ovf),
    .zero   (w_zero)
  );

  cmpdec_dadj #(.W(W)) u_dadj (
    .a     (d_lo),
    .c_in  (fin.c),
    .h_in  (fin.h),
    .d_in  (fin.d),
    .res   (da_res),
    .c_out (da_c)
  );

  assign com_res = ~d_lo;

  always_comb begin
    fnx    = fin;
    res_nx = '0;
    we_nx  = 1'b0;
    case (op)
      OP_COM: begin
        res_nx = {{(DW-W){1'b0}}, com_res};
        we_nx  = 1'b1;
        fnx.z  = (com_res == '0);
        fnx.s  = com_res[W-1];
        fnx.v  = 1'b0;
      end
      OP_CP, OP_CPC: begin
        fnx.c = sb_borrow;
        fnx.z = (op == OP_CPC) ? (fin.z & sb_zero) : sb_zero;
        fnx.s = sb_diff[W-1];
        fnx.v = sb_ovf;
      end
      OP_DEC: begin
        res_nx = {{(DW-W){1'b0}}, sb_diff};
        we_nx  = 1'b1;
        fnx.z  = sb_zero;
        fnx.s  = sb_diff[W-1];
        fnx.v  = sb_ovf;
      end
      OP_DECW: begin
        res_nx = w_diff;
        we_nx  = 1'b1;
        fnx.z  = w_zero;
        fnx.s  = w_diff[DW-1];
        fnx.v  = w_ovf;
      end
      OP_DA: begin
        res_nx = {{(DW-W){1'b0}}, da_res};
        we_nx  = 1'b1;
        fnx.c  = da_c;
        fnx.z  = (da_res == '0);
        fnx.s  = da_res[W-1];
        fnx.v  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & we_nx;
      if (in_valid) begin
        result    <= res_nx;
        flags_out <= fnx;
      end
    end
  end

  logic opc_is_cmp, opc_is_com, opc_is_dec;
  assign opc_is_cmp = (opcode >= OPC_W'(8'hA2)) && (opcode <= OPC_W'(8'hA9));
  assign opc_is_com = !pre_en && (opcode[OPC_W-1:1] == (OPC_W-1)'(8'h60 >> 1));
  assign opc_is_dec = !pre_en && (opcode[OPC_W-1:1] == (OPC_W-1)'(8'h30 >> 1));

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && $stable(flags_out) && $stable(result)));

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_is_cmp) |=> !wr_en);

  assert_com_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_is_com) |=> (flags_out[5] == $past(flags_in[5]) &&
                                  flags_out[1:0] == $past(flags_in[1:0]) &&
                                  !flags_out[2]));

  assert_dec_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_is_dec) |=> (flags_out[5] == $past(flags_in[5]) &&
                                  flags_out[1:0] == $past(flags_in[1:0])));

  assert_cpc_zero_chain_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_CPC && !flags_in[4]) |=> !flags_out[4]);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && flags_out == '0 && result == '0));
endmodule

// File: tb/test_cmpdec_alu.sv
module test_cmpdec_alu;
  typedef struct packed {
    logic        pre;
    logic [7:0]  opc;
    logic [15:0] dst;
    logic [7:0]  src;
    logic [5:0]  fin;
    logic [15:0] eres;
    logic        ewe;
    logic [5:0]  efl;
  } vec_t;

  localparam int NV = 26;
  // flags {C,Z,S,V,D,H}
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h60, 16'h000F, 8'h00, 6'b100011, 16'h00F0, 1'b1, 6'b101011}, // R2
    '{1'b0, 8'h61, 16'h00FF, 8'h00, 6'b000100, 16'h0000, 1'b1, 6'b010000}, // R2
    '{1'b0, 8'hA2, 16'h0005, 8'h07, 6'b000011, 16'h0000, 1'b0, 6'b101011}, // R3
    '{1'b0, 8'hA4, 16'h0080, 8'h01, 6'b000000, 16'h0000, 1'b0, 6'b000100}, // R3
    '{1'b0, 8'hA6, 16'h0042, 8'h42, 6'b100000, 16'h0000, 1'b0, 6'b010000}, // R3
    '{1'b0, 8'hA9, 16'h0003, 8'h03, 6'b000000, 16'h0000, 1'b0, 6'b010000}, // R3 top of range
    '{1'b0, 8'hA3, 16'h0001, 8'h80, 6'b000000, 16'h0000, 1'b0, 6'b101100}, // R3
    '{1'b1, 8'hA2, 16'h0010, 8'h0F, 6'b110000, 16'h0000, 1'b0, 6'b010000}, // R4
    '{1'b1, 8'hA4, 16'h0010, 8'h0F, 6'b100000, 16'h0000, 1'b0, 6'b000000}, // R4
    '{1'b1, 8'hA9, 16'h0000, 8'h00, 6'b110000, 16'h0000, 1'b0, 6'b101000}, // R4
    '{1'b0, 8'h30, 16'h0080, 8'h00, 6'b100011, 16'h007F, 1'b1, 6'b100111}, // R5
    '{1'b0, 8'h31, 16'h0001, 8'h00, 6'b000000, 16'h0000, 1'b1, 6'b010000}, // R5
    '{1'b0, 8'h30, 16'h0000, 8'h00, 6'b000000, 16'h00FF, 1'b1, 6'b001000}, // R5
    '{1'b0, 8'h80, 16'h0100, 8'h00, 6'b100000, 16'h00FF, 1'b1, 6'b100000}, // R6
    '{1'b0, 8'h81, 16'h8000, 8'h00, 6'b000000, 16'h7FFF, 1'b1, 6'b000100}, // R6
    '{1'b0, 8'h80, 16'h0001, 8'h00, 6'b000011, 16'h0000, 1'b1, 6'b010011}, // R6
    '{1'b0, 8'h80, 16'h0000, 8'h00, 6'b000000, 16'hFFFF, 1'b1, 6'b001000}, // R6
    '{1'b0, 8'h40, 16'h000A, 8'h00, 6'b000000, 16'h0010, 1'b1, 6'b000000}, // R7
    '{1'b0, 8'h41, 16'h009A, 8'h00, 6'b000000, 16'h0000, 1'b1, 6'b110000}, // R7
    '{1'b0, 8'h40, 16'h0012, 8'h00, 6'b000001, 16'h0018, 1'b1, 6'b000001}, // R7
    '{1'b0, 8'h40, 16'h0025, 8'h00, 6'b100000, 16'h0085, 1'b1, 6'b101000}, // R7
    '{1'b0, 8'h40, 16'h00EF, 8'h00, 6'b100011, 16'h0089, 1'b1, 6'b101011}, // R8
    '{1'b0, 8'h41, 16'h0023, 8'h00, 6'b000010, 16'h0023, 1'b1, 6'b000010}, // R8
    '{1'b0, 8'h00, 16'h0055, 8'h11, 6'b110101, 16'h0000, 1'b0, 6'b110101}, // R1
    '{1'b1, 8'h60, 16'h0055, 8'h11, 6'b001010, 16'h0000, 1'b0, 6'b001010}, // R1
    '{1'b0, 8'hAA, 16'h0055, 8'h55, 6'b010100, 16'h0000, 1'b0, 6'b010100}  // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        pre_en = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] dst_in = '0;
  logic [7:0]  src_in = '0;
  logic [5:0]  flags_in = '0;
  logic        out_valid, wr_en;
  logic [15:0] result;
  logic [5:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmpdec_alu i_cmpdec_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pre_en(pre_en),
    .opcode(opcode), .dst_in(dst_in), .src_in(src_in), .flags_in(flags_in),
    .out_valid(out_valid), .wr_en(wr_en), .result(result), .flags_out(flags_out)
  );

  function automatic string tag_of(input vec_t v);
    if (v.pre) return (v.opc >= 8'hA2 && v.opc <= 8'hA9) ? "R4" : "R1";
    if (v.opc >= 8'hA2 && v.opc <= 8'hA9) return "R3";
    case (v.opc[7:1])
      7'h30: return "R2";
      7'h18: return "R5";
      7'h40: return "R6";
      7'h20: return (v.fin[1]) ? "R8" : "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; pre_en = v.pre; opcode = v.opc;
    dst_in = v.dst; src_in = v.src; flags_in = v.fin;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {2'b00, out_valid, wr_en, result, flags_out}, 24'h0);
    rst = 1'b0;

    foreach (VT[i]) begin
      issue(VT[i]);
      check(tag_of(VT[i]), {2'b00, out_valid, wr_en, result, flags_out},
            {2'b00, 1'b1, VT[i].ewe, VT[i].eres, VT[i].efl});
    end

    // R9 idle: valid/write drop, result and flags hold
    @(negedge clk);
    check("R9", {2'b00, out_valid, wr_en, result, flags_out},
          {2'b00, 1'b0, 1'b0, VT[NV-1].eres, VT[NV-1].efl});

    // R9 idle after a write-back instruction
    issue(VT[0]);
    @(negedge clk);
    check("R9", {2'b00, out_valid, wr_en, result, flags_out},
          {2'b00, 1'b0, 1'b0, VT[0].eres, VT[0].efl});

    // R10 reset beats a valid input
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; pre_en = 1'b0; opcode = 8'h61;
    dst_in = 16'h0000; flags_in = 6'b111111;
    @(negedge clk);
    check("R10", {2'b00, out_valid, wr_en, result, flags_out}, 24'h0);
    rst = 1'b0; in_valid = 1'b0;

    // R4 chain: two-byte compare 0x1234 vs 0x1234, low byte then high byte
    issue('{1'b1, 8'hA2, 16'h0034, 8'h34, 6'b010000, 16'h0, 1'b0, 6'b0});
    issue('{1'b1, 8'hA2, 16'h0012, 8'h12, flags_out, 16'h0, 1'b0, 6'b0});
    check("R4", {18'h0, flags_out}, {18'h0, 6'b010000});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule